// File: doc/BRIEF.md
# Serial Flash Secured OTP Controller

This block is the instruction-handling part of a serial NOR flash that owns a separate 4096-bit one-time-programmable (OTP) area and a one-byte security register. It runs on the system clock and treats the serial clock and chip select as sampled inputs. While chip select is low it collects instruction bits. In 1-bit mode it takes one bit per serial clock rise. In 4-bit mode it takes a nibble per rise. It then acts on five instructions: set write enable, enter OTP mode, leave OTP mode, read the security register and write the security register.

Entering OTP mode hides the main array. The `region_sel_o` output then steers the ordinary read and program paths of the surrounding flash to the OTP area, and leaving OTP mode hands them back to the main array. The lock-down bit can be set once, and only from software with the write-enable latch set. After that it stays set. A set lock bit blocks OTP programming and leaves only read-type access while in OTP mode. Any instruction that changes state runs only if chip select rises right after a whole instruction byte. Each accepted instruction gives a one-cycle pulse on its own bit of `acc_o`.

Top module: `otp_sec_ctrl`

## Requirements
- R1: After reset, region_sel_o and otp_program_allowed_o are 0, acc_o is 0, dout_oe_o is 0, and the security register reads write-enable 0, OTP mode 0, and lock equal to the lock_preset_i value that was present during reset.
- R2: With qpi_i low, one instruction byte is 8 serial clock rises. Bits are taken from sio_i[0] most significant first, and sio_i[3:1] have no effect.
- R3: With qpi_i high, one instruction byte is 2 serial clock rises, each taking sio_i[3:0] as a nibble. The high nibble comes first and sio_i[3] is the most significant bit of the nibble.
- R4: An accepted enter-OTP instruction sets region_sel_o to 1. region_sel_o changes only in the cycle that an enter or exit pulse is reported.
- R5: An accepted exit-OTP instruction sets region_sel_o to 0.
- R6: The write-enable instruction sets the write-enable latch, which is security register bit 2.
- R7: The write-security-register instruction is accepted only while the write-enable latch is 1. It then sets the lock bit (security register bit 1) and clears the latch. Without the latch it is rejected: no pulse and no state change.
- R8: Once the lock bit is 1, no instruction clears it. Only a reset with lock_preset_i low clears it.
- R9: otp_program_allowed_o equals OTP mode AND NOT lock. While OTP mode and lock are both 1, write-enable and write-security-register are rejected with no pulse and no state change.
- R10: A state-changing instruction runs only if chip select rises after exactly one complete byte. Fewer bits, a partial byte, or extra bits cause it to be dropped with no pulse and no state change, and the write-enable latch is kept.
- R11: The read-security-register instruction needs no chip-select boundary. Once its opcode byte completes, dout_oe_o is 1 and the register {5'b0, write-enable, lock, OTP mode} is driven most significant first. In 1-bit mode it is driven on dout_o[0] one bit per serial clock rise. In 4-bit mode it is driven on dout_o[3:0] a nibble per rise. The value repeats for as long as chip select stays low. The read changes no state.
- R12: Opcodes other than the five configured ones give no pulse and no state change, and the bits that follow them until chip select rises are ignored.
- R13: acc_o bits are WREN=0, enter=1, exit=2, read-register=3, write-register=4. At most one bit is high, for one cycle. A write-type pulse appears in the cycle after the clock edge that samples chip select high. The read pulse appears one cycle after the opcode byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_preset_i | input | 1 | Value loaded into the lock bit during reset |
| qpi_i | input | 1 | 0 selects 1-bit instruction mode, 1 selects 4-bit mode; stable while chip select is low |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, sampled; a rise moves data |
| sio_i | input | 4 | Serial data in |
| region_sel_o | output | 1 | 0 routes access to the main array, 1 to the OTP area |
| otp_program_allowed_o | output | 1 | OTP programming currently permitted |
| acc_o | output | 5 | One-cycle acceptance pulse per instruction kind |
| dout_o | output | 4 | Security register data out |
| dout_oe_o | output | 1 | dout_o is valid and driven |

## Verification
The bench builds the block with its default 8-bit byte and 4-bit lane width, and with the default opcode values. That keeps the opcode space at 256 values, so every value can be sent in 1-bit mode and in 4-bit mode, and once more with the lock preset high. After each instruction the whole security register is read back through the block's own read instruction and compared with a model kept in the bench. Sweeping chip-select rise points from one bit up to two full bytes covers every off-boundary rejection. A short sequence in locked OTP mode covers the gating of write-enable and of the register write.

// File: rtl/otp_sec_pkg.sv
// Package otp_sec_pkg
// Shared command encoding and acceptance-pulse bit positions for the
// secured OTP controller. Assumes five recognised instructions.
package otp_sec_pkg;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_WREN  = 3'd1,
        CMD_ENTER = 3'd2,
        CMD_EXIT  = 3'd3,
        CMD_RDSEC = 3'd4,
        CMD_WRSEC = 3'd5
    } cmd_e;

    localparam int ACC_W     = 5;
    localparam int ACC_WREN  = 0;
    localparam int ACC_ENTER = 1;
    localparam int ACC_EXIT  = 2;
    localparam int ACC_RDSEC = 3;
    localparam int ACC_WRSEC = 4;

    localparam int SEC_MODE_BIT = 0;
    localparam int SEC_LOCK_BIT = 1;
    localparam int SEC_WEL_BIT  = 2;

endpackage

// File: rtl/otp_sec_shift.sv
// Module otp_sec_shift
// Collects instruction bits while chip select is low, one bit per serial
// clock rise in 1-bit mode or one lane-wide nibble in 4-bit mode. Latches
// the first complete byte as the opcode and reports whether the bit count
// sits on exactly one completed byte. Assumes qpi_i is stable in a frame
// and that BYTE_W is a multiple of LANE_W.
module otp_sec_shift #(
    parameter int BYTE_W = 8,
    parameter int LANE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low_i,
    input  logic              sclk_rise_i,
    input  logic              qpi_i,
    input  logic [LANE_W-1:0] sio_i,
    output logic [BYTE_W-1:0] opcode_o,
    output logic              first_done_o,
    output logic              exact_o
);

    localparam int CNT_W = $clog2(BYTE_W) + 1;
    localparam logic [CNT_W-1:0] STEP_1 = CNT_W'(1);
    localparam logic [CNT_W-1:0] STEP_Q = CNT_W'(LANE_W);
    localparam logic [CNT_W-1:0] FULL   = CNT_W'(BYTE_W);

    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] shreg_nxt;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [CNT_W-1:0]  bitcnt_nxt;
    logic [1:0]        nbytes_q;

    // Next shift value and bit count for the current lane width.
    always_comb begin
        if (qpi_i) begin
            shreg_nxt  = {shreg_q[BYTE_W-LANE_W-1:0], sio_i};
            bitcnt_nxt = bitcnt_q + STEP_Q;
        end else begin
            shreg_nxt  = {shreg_q[BYTE_W-2:0], sio_i[0]};
            bitcnt_nxt = bitcnt_q + STEP_1;
        end
    end

    // Bit and byte counting, opcode capture; cleared while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_low_i) begin
            shreg_q      <= '0;
            bitcnt_q     <= '0;
            nbytes_q     <= '0;
            first_done_o <= 1'b0;
            if (!rst_n) begin
                opcode_o <= '0;
            end
        end else begin
            first_done_o <= 1'b0;
            if (sclk_rise_i) begin
                shreg_q <= shreg_nxt;
                if (bitcnt_nxt >= FULL) begin
                    bitcnt_q <= '0;
                    if (nbytes_q != 2'd3) begin
                        nbytes_q <= nbytes_q + 2'd1;
                    end
                    if (nbytes_q == 2'd0) begin
                        opcode_o     <= shreg_nxt;
                        first_done_o <= 1'b1;
                    end
                end else begin
                    bitcnt_q <= bitcnt_nxt;
                end
            end
        end
    end

    // Frame ends on a legal boundary only after exactly one whole byte.
    always_comb begin
        exact_o = (bitcnt_q == '0) && (nbytes_q == 2'd1);
    end

endmodule

// File: rtl/otp_sec_decode.sv
// Module otp_sec_decode
// Maps a captured opcode onto the internal command code. Opcode values are
// parameters; any other value decodes to CMD_NONE and is ignored.
module otp_sec_decode
    import otp_sec_pkg::*;
#(
    parameter int              BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] OP_WREN  = 8'h06,
    parameter logic [BYTE_W-1:0] OP_ENTER = 8'hB1,
    parameter logic [BYTE_W-1:0] OP_EXIT  = 8'hC1,
    parameter logic [BYTE_W-1:0] OP_RDSEC = 8'h2B,
    parameter logic [BYTE_W-1:0] OP_WRSEC = 8'h2F
) (
    input  logic [BYTE_W-1:0] opcode_i,
    output cmd_e              cmd_o
);

    // Pure lookup from opcode to command class.
    always_comb begin
        if (opcode_i == OP_WREN) begin
            cmd_o = CMD_WREN;
        end else if (opcode_i == OP_ENTER) begin
            cmd_o = CMD_ENTER;
        end else if (opcode_i == OP_EXIT) begin
            cmd_o = CMD_EXIT;
        end else if (opcode_i == OP_RDSEC) begin
            cmd_o = CMD_RDSEC;
        end else if (opcode_i == OP_WRSEC) begin
            cmd_o = CMD_WRSEC;
        end else begin
            cmd_o = CMD_NONE;
        end
    end

endmodule

// File: rtl/otp_sec_state.sv
// Module otp_sec_state
// Holds the write-enable latch, the OTP-mode flag and the lock-down bit and
// issues the acceptance pulses. Write-type commands arrive as an execute
// strobe at a legal chip-select rise; the read command arrives as a start
// strobe when its opcode completes. Assumes the two strobes never coincide.
module otp_sec_state
    import otp_sec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_preset_i,
    input  logic             exec_i,
    input  logic             rd_start_i,
    input  cmd_e             cmd_i,
    output logic             wel_o,
    output logic             mode_o,
    output logic             lock_o,
    output logic [ACC_W-1:0] acc_o
);

    logic gated;

    // Locked OTP mode admits only read-type and mode commands.
    always_comb begin
        gated = mode_o && lock_o;
    end

    // Register updates and one-cycle acceptance pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_o  <= 1'b0;
            mode_o <= 1'b0;
            lock_o <= lock_preset_i;
            acc_o  <= '0;
        end else begin
            acc_o <= '0;
            if (rd_start_i) begin
                acc_o[ACC_RDSEC] <= 1'b1;
            end
            if (exec_i) begin
                case (cmd_i)
                    CMD_WREN: begin
                        if (!gated) begin
                            wel_o           <= 1'b1;
                            acc_o[ACC_WREN] <= 1'b1;
                        end
                    end
                    CMD_ENTER: begin
                        mode_o           <= 1'b1;
                        acc_o[ACC_ENTER] <= 1'b1;
                    end
                    CMD_EXIT: begin
                        mode_o          <= 1'b0;
                        acc_o[ACC_EXIT] <= 1'b1;
                    end
                    CMD_WRSEC: begin
                        if (wel_o && !gated) begin
                            lock_o           <= 1'b1;
                            wel_o            <= 1'b0;
                            acc_o[ACC_WRSEC] <= 1'b1;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);

    // R7
    wrsec_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o[ACC_WRSEC] |-> (!wel_o && $past(wel_o) && lock_o));

    // R9
    locked_no_wren_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o && lock_o && !wel_o) |=> !acc_o[ACC_WREN]);

endmodule

// File: rtl/otp_sec_readout.sv
// Module otp_sec_readout
// Streams the security register out, most significant first, one bit or
// one nibble per serial clock rise, reloading the live register value
// after each whole byte for as long as chip select stays low.
module otp_sec_readout #(
    parameter int BYTE_W = 8,
    parameter int LANE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low_i,
    input  logic              sclk_rise_i,
    input  logic              qpi_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] sec_i,
    output logic [LANE_W-1:0] dout_o,
    output logic              oe_o
);

    localparam int CNT_W = $clog2(BYTE_W) + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic              active_q;
    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  ptr_q;
    logic [CNT_W-1:0]  ptr_nxt;

    // Position after the next rise for the active lane width.
    always_comb begin
        ptr_nxt = ptr_q + (qpi_i ? CNT_W'(LANE_W) : CNT_W'(1));
    end

    // Output shift register with per-byte reload.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_low_i) begin
            active_q <= 1'b0;
            sh_q     <= '0;
            ptr_q    <= '0;
        end else if (load_i) begin
            active_q <= 1'b1;
            sh_q     <= sec_i;
            ptr_q    <= '0;
        end else if (active_q && sclk_rise_i) begin
            if (ptr_nxt >= FULL) begin
                sh_q  <= sec_i;
                ptr_q <= '0;
            end else begin
                sh_q  <= qpi_i ? {sh_q[BYTE_W-LANE_W-1:0], {LANE_W{1'b0}}}
                               : {sh_q[BYTE_W-2:0], 1'b0};
                ptr_q <= ptr_nxt;
            end
        end
    end

    // Present the head of the shift register on the active lanes.
    always_comb begin
        dout_o = '0;
        if (qpi_i) begin
            dout_o = sh_q[BYTE_W-1 -: LANE_W];
        end else begin
            dout_o[0] = sh_q[BYTE_W-1];
        end
        oe_o = active_q && cs_low_i;
    end

    // R11
    load_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && cs_low_i) |=> (active_q && sh_q == $past(sec_i)));

endmodule

// File: rtl/otp_sec_ctrl.sv
// Module otp_sec_ctrl
// Top of the secured OTP instruction controller. Samples chip select and
// the serial clock on the system clock, finds edges, and ties together the
// bit collector, the opcode decoder, the state registers and the register
// readout. Assumes the serial clock is at most half the system clock rate.
module otp_sec_ctrl
    import otp_sec_pkg::*;
#(
    parameter int              BYTE_W   = 8,
    parameter int              LANE_W   = 4,
    parameter logic [BYTE_W-1:0] OP_WREN  = 8'h06,
    parameter logic [BYTE_W-1:0] OP_ENTER = 8'hB1,
    parameter logic [BYTE_W-1:0] OP_EXIT  = 8'hC1,
    parameter logic [BYTE_W-1:0] OP_RDSEC = 8'h2B,
    parameter logic [BYTE_W-1:0] OP_WRSEC = 8'h2F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_preset_i,
    input  logic              qpi_i,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic [LANE_W-1:0] sio_i,
    output logic              region_sel_o,
    output logic              otp_program_allowed_o,
    output logic [ACC_W-1:0]  acc_o,
    output logic [LANE_W-1:0] dout_o,
    output logic              dout_oe_o
);

    logic              cs_q;
    logic              sclk_q;
    logic              cs_low;
    logic              cs_rise;
    logic              sclk_rise;
    logic [BYTE_W-1:0] opcode;
    logic              first_done;
    logic              exact;
    cmd_e              cmd;
    logic              wel;
    logic              mode;
    logic              lock;
    logic [BYTE_W-1:0] sec_byte;

    // Previous samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_n_i;
            sclk_q <= sclk_i;
        end
    end

    // Edge strobes for chip select and the serial clock.
    always_comb begin
        cs_low    = !cs_n_i;
        cs_rise   = cs_n_i && !cs_q;
        sclk_rise = sclk_i && !sclk_q && !cs_n_i;
    end

    otp_sec_shift #(
        .BYTE_W (BYTE_W),
        .LANE_W (LANE_W)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_low_i     (cs_low),
        .sclk_rise_i  (sclk_rise),
        .qpi_i        (qpi_i),
        .sio_i        (sio_i),
        .opcode_o     (opcode),
        .first_done_o (first_done),
        .exact_o      (exact)
    );

    otp_sec_decode #(
        .BYTE_W   (BYTE_W),
        .OP_WREN  (OP_WREN),
        .OP_ENTER (OP_ENTER),
        .OP_EXIT  (OP_EXIT),
        .OP_RDSEC (OP_RDSEC),
        .OP_WRSEC (OP_WRSEC)
    ) u_decode (
        .opcode_i (opcode),
        .cmd_o    (cmd)
    );

    otp_sec_state u_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .lock_preset_i (lock_preset_i),
        .exec_i        (cs_rise && exact),
        .rd_start_i    (first_done && (cmd == CMD_RDSEC)),
        .cmd_i         (cmd),
        .wel_o         (wel),
        .mode_o        (mode),
        .lock_o        (lock),
        .acc_o         (acc_o)
    );

    // Security register image seen by the readout.
    always_comb begin
        sec_byte               = '0;
        sec_byte[SEC_MODE_BIT] = mode;
        sec_byte[SEC_LOCK_BIT] = lock;
        sec_byte[SEC_WEL_BIT]  = wel;
    end

    otp_sec_readout #(
        .BYTE_W (BYTE_W),
        .LANE_W (LANE_W)
    ) u_readout (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_low_i    (cs_low),
        .sclk_rise_i (sclk_rise),
        .qpi_i       (qpi_i),
        .load_i      (first_done && (cmd == CMD_RDSEC)),
        .sec_i       (sec_byte),
        .dout_o      (dout_o),
        .oe_o        (dout_oe_o)
    );

    // Region steering and program permission.
    always_comb begin
        region_sel_o          = mode;
        otp_program_allowed_o = mode && !lock;
    end

    // R13
    acc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_o));

    // R10
    write_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o[ACC_WREN] || acc_o[ACC_ENTER] || acc_o[ACC_EXIT] || acc_o[ACC_WRSEC])
        |-> ($past(cs_n_i) && !$past(cs_q)));

    // R4
    region_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(region_sel_o) |-> (acc_o[ACC_ENTER] || acc_o[ACC_EXIT]));

endmodule

// File: tb/sim_otp_sec_ctrl.sv
`timescale 1ns/1ps
module sim_otp_sec_ctrl;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_ENTER = 8'hB1;
    localparam logic [7:0] OP_EXIT  = 8'hC1;
    localparam logic [7:0] OP_RDSEC = 8'h2B;
    localparam logic [7:0] OP_WRSEC = 8'h2F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       preset = 1'b0;
    logic       qpi = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic [3:0] sio = 4'h0;
    logic       region_sel;
    logic       prog_ok;
    logic [4:0] acc;
    logic [3:0] dout;
    logic       dout_oe;

    int  tests = 0;
    int  fails = 0;
    int  pc[5];
    bit  done = 0;
    bit  m_wel, m_mode, m_lock;

    always #4 clk = ~clk;

    otp_sec_ctrl u0 (
        .clk                   (clk),
        .rst_n                 (rst_n),
        .lock_preset_i         (preset),
        .qpi_i                 (qpi),
        .cs_n_i                (cs_n),
        .sclk_i                (sclk),
        .sio_i                 (sio),
        .region_sel_o          (region_sel),
        .otp_program_allowed_o (prog_ok),
        .acc_o                 (acc),
        .dout_o                (dout),
        .dout_oe_o             (dout_oe)
    );

    // Count acceptance pulses, sampled between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 5; i++) begin
                if (acc[i]) pc[i]++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_pc();
        for (int i = 0; i < 5; i++) pc[i] = 0;
    endtask

    function automatic logic [7:0] model_byte();
        return {5'b0, m_wel, m_lock, m_mode};
    endfunction

    task automatic pulse(input logic [3:0] v);
        @(negedge clk);
        sio  = v;
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
    endtask

    // Send nclk serial clocks of pat (MSB first) with chip select low.
    task automatic frame(input logic [15:0] pat, input int nclk);
        logic [15:0] t;
        @(negedge clk);
        cs_n = 1'b0;
        for (int c = 0; c < nclk; c++) begin
            if (qpi) begin
                t = pat >> (12 - 4 * c);
                pulse(t[3:0]);
            end else begin
                pulse({3'($urandom_range(7, 0)), pat[15 - c]});
            end
        end
    endtask

    task automatic end_frame();
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Read the security register twice in one frame.
    task automatic read_sec(output logic [7:0] b0, output logic [7:0] b1);
        int units;
        units = qpi ? 2 : 8;
        b0 = '0;
        b1 = '0;
        frame({OP_RDSEC, 8'h00}, units);
        @(negedge clk);
        chk("R11 output enable", int'(dout_oe), 1);
        for (int k = 0; k < 2; k++) begin
            for (int u = 0; u < units; u++) begin
                if (k == 0) b0 = qpi ? {b0[3:0], dout} : {b0[6:0], dout[0]};
                else        b1 = qpi ? {b1[3:0], dout} : {b1[6:0], dout[0]};
                pulse(4'h0);
                @(negedge clk);
            end
        end
        end_frame();
    endtask

    task automatic check_state(input string tag);
        logic [7:0] b0, b1;
        chk({tag, " R4 region"}, int'(region_sel), int'(m_mode));
        chk({tag, " R9 program allowed"}, int'(prog_ok), int'(m_mode && !m_lock));
        clear_pc();
        read_sec(b0, b1);
        chk({tag, " R11 register first"}, int'(b0), int'(model_byte()));
        chk({tag, " R11 register repeat"}, int'(b1), int'(model_byte()));
        chk({tag, " R11 read pulse"}, pc[3], 1);
    endtask

    // Issue one whole-byte instruction and compare against the model.
    task automatic do_op(input logic [7:0] op);
        int e[5];
        bit gated;
        for (int i = 0; i < 5; i++) e[i] = 0;
        gated = m_mode && m_lock;
        if (op == OP_WREN && !gated) begin m_wel = 1; e[0] = 1; end
        else if (op == OP_ENTER) begin m_mode = 1; e[1] = 1; end
        else if (op == OP_EXIT) begin m_mode = 0; e[2] = 1; end
        else if (op == OP_RDSEC) begin e[3] = 1; end
        else if (op == OP_WRSEC && m_wel && !gated) begin
            m_lock = 1; m_wel = 0; e[4] = 1;
        end
        clear_pc();
        frame({op, 8'h00}, qpi ? 2 : 8);
        end_frame();
        chk($sformatf("R13 R12 R6 wren pulse op=%0h", op), pc[0], e[0]);
        chk($sformatf("R13 R4 enter pulse op=%0h", op), pc[1], e[1]);
        chk($sformatf("R13 R5 exit pulse op=%0h", op), pc[2], e[2]);
        chk($sformatf("R13 R11 read pulse op=%0h", op), pc[3], e[3]);
        chk($sformatf("R13 R7 wrsec pulse op=%0h", op), pc[4], e[4]);
        check_state($sformatf("R2 R3 R8 op=%0h", op));
    endtask

    task automatic do_reset(input logic p);
        @(negedge clk);
        rst_n  = 1'b0;
        preset = p;
        cs_n   = 1'b1;
        sclk   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        preset = ~p;
        @(negedge clk);
        m_wel = 0; m_mode = 0; m_lock = p;
        chk("R1 region", int'(region_sel), 0);
        chk("R1 program allowed", int'(prog_ok), 0);
        chk("R1 pulses", int'(acc), 0);
        chk("R1 output enable", int'(dout_oe), 0);
        check_state("R1 reset");
    endtask

    // Drop the frame at every off-boundary length.
    task automatic trunc_sweep(input logic [7:0] op, input int maxclk);
        int full;
        full = qpi ? 2 : 8;
        for (int n = 1; n <= maxclk; n++) begin
            if (n != full) begin
                clear_pc();
                frame({op, op}, n);
                end_frame();
                chk($sformatf("R10 no pulse op=%0h n=%0d", op, n),
                    pc[0] + pc[1] + pc[2] + pc[4], 0);
                check_state($sformatf("R10 unchanged n=%0d", n));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // Full opcode sweep in 1-bit mode, then 4-bit mode, unlocked start.
        qpi = 1'b0;
        do_reset(1'b0);
        for (int op = 0; op < 256; op++) do_op(8'(op));
        qpi = 1'b1;
        do_reset(1'b0);
        for (int op = 0; op < 256; op++) do_op(8'(op));

        // Off-boundary rejection keeps the write-enable latch and region.
        for (int q = 0; q < 2; q++) begin
            qpi = q[0];
            do_reset(1'b0);
            do_op(OP_WREN);
            trunc_sweep(OP_WRSEC, q[0] ? 4 : 16);
            trunc_sweep(OP_ENTER, q[0] ? 4 : 16);
            do_op(OP_WRSEC);
        end

        // Locked start; lock survives every opcode.
        qpi = 1'b0;
        do_reset(1'b1);
        for (int op = 0; op < 256; op++) do_op(8'(op));

        // Locked OTP mode gates write commands; exit restores them.
        do_reset(1'b1);
        do_op(OP_ENTER);
        do_op(OP_WREN);
        do_op(OP_WRSEC);
        do_op(OP_EXIT);
        do_op(OP_WREN);
        do_op(OP_ENTER);
        do_op(OP_WRSEC);
        do_op(OP_EXIT);
        do_op(OP_WRSEC);

        // Write without the latch is rejected while unlocked.
        do_reset(1'b0);
        do_op(OP_WRSEC);
        do_op(OP_ENTER);
        do_op(OP_WREN);
        do_op(OP_WRSEC);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule